// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns the refresh duty of an asynchronous DRAM controller. After reset it lets a start-up delay run out, then performs a fixed minimum number of dummy refresh cycles. Only after the last of these does it raise the memory-ready flag. From then on it owes one refresh every fixed interval. The interval is derived from the clock frequency, the retention period and the row count, less a small safety margin, so that every row is refreshed within the retention period.

Each refresh is a CAS-before-RAS cycle. The internal row counter of the DRAM supplies the row, so no address is driven. The write-enable strobe stays high for the whole cycle, which means the refresh can never be decoded as the test-mode entry command. The block competes with the access sequencer for the strobes through a request/grant pair. Owed refreshes collect in a small backlog, so a page burst may postpone a few of them. When the backlog is full, an urgent flag tells the access sequencer to close its burst. A one-cycle done pulse marks the end of each refresh.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and directly after it: `ras_n_o`, `cas_n_o` and `we_n_o` are high, and `ref_req_o`, `ref_urgent_o`, `ref_done_o` and `mem_ready_o` are low.
- R2: `ref_req_o` stays low for the first START_CYC clock edges after reset release (START_CYC = CLK_MHZ x STARTUP_US). It goes high in the cycle that follows edge START_CYC.
- R3: `mem_ready_o` rises in the cycle after the INIT_CYCLES-th `ref_done_o` pulse and never falls again until reset. No refresh owed by the interval timer is counted before then.
- R4: In a refresh, `cas_n_o` falls T_CSR cycles before `ras_n_o` falls. `cas_n_o` stays low for as long as `ras_n_o` is low, and both rise in the same cycle.
- R5: `ras_n_o` stays low for exactly T_RAS cycles. It is followed by T_RP cycles in which both strobes are high, and no refresh starts during those cycles. Before CAS falls there are T_WSU cycles in which the strobes are high and write-enable is high.
- R6: `we_n_o` is high in every cycle.
- R7: A refresh begins (the write-enable setup cycles start) only on the clock edge after one at which `ref_req_o` and `ref_gnt_i` were both high. `ref_req_o` stays high until the refresh ends. With no grant, the strobes stay high.
- R8: `ref_done_o` is a one-cycle pulse in the last precharge cycle of each refresh.
- R9: Once ready, one refresh is owed every INTERVAL cycles, where INTERVAL = CLK_MHZ x RETENTION_US / ROWS - MARGIN. With grant held high, successive done pulses are INTERVAL cycles apart.
- R10: The backlog of owed refreshes saturates at MAX_PENDING, and an owed refresh that arrives at a full backlog is lost. `ref_urgent_o` is high exactly when the backlog is full. Each completed refresh after ready removes one entry from the backlog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_gnt_i | input | 1 | Grant of the strobes from the access sequencer |
| ref_req_o | output | 1 | Refresh wants, or holds, the strobes |
| ref_urgent_o | output | 1 | Backlog full; the running burst must close |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, always high |
| ref_done_o | output | 1 | One-cycle pulse at the end of each refresh |
| mem_ready_o | output | 1 | Initialization complete; accesses allowed |

## Verification
The bench holds the grant low across the end of the start-up delay. A design that let a refresh start without a grant, or that counted initialization cycles that never ran, would raise ready early. It then grants back-to-back initialization refreshes. A design that counted one refresh too many or too few would move the ready edge by a full refresh length. Later the bench withholds the grant for several intervals. This catches a backlog that wraps instead of saturating, an urgent flag that is off by one, and a drain that runs one refresh too many or too few. A behavioural model compares every strobe on every cycle, so a write-enable glitch or a RAS that falls before CAS shows up in the cycle where it happens.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSU,
    PH_CSU,
    PH_ACT,
    PH_PRE
  } ref_phase_e;

  typedef enum logic [1:0] {
    PU_WAIT,
    PU_INIT,
    PU_READY
  } pu_state_e;

  // Whole clock cycles covering a time in ns, never less than one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/dram_ref_powerup.sv
module dram_ref_powerup #(
  parameter int unsigned START_CYC   = 40000,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  output logic init_req_o,
  output logic ready_o
);
  import dram_ref_pkg::*;

  localparam int unsigned WW = $clog2(START_CYC + 1);
  localparam int unsigned IW = $clog2(INIT_CYCLES + 1);

  pu_state_e      state_q, state_d;
  logic [WW-1:0]  wait_q, wait_d;
  logic [IW-1:0]  icnt_q, icnt_d;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    icnt_d  = icnt_q;
    case (state_q)
      PU_WAIT: begin
        if (wait_q == WW'(START_CYC - 1)) state_d = PU_INIT;
        else                              wait_d  = wait_q + 1'b1;
      end
      PU_INIT: begin
        if (done_i) begin
          if (icnt_q == IW'(INIT_CYCLES - 1)) state_d = PU_READY;
          else                                icnt_d  = icnt_q + 1'b1;
        end
      end
      default: state_d = PU_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PU_WAIT;
      wait_q  <= '0;
      icnt_q  <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      icnt_q  <= icnt_d;
    end
  end

  assign init_req_o = (state_q == PU_INIT);
  assign ready_o    = (state_q == PU_READY);

  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
  a_r3_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(done_i));
  a_r2_quiet_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PU_WAIT) |-> !init_req_o && !ready_o);

endmodule

// File: rtl/dram_ref_interval.sv
module dram_ref_interval #(
  parameter int unsigned INTERVAL = 3109
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(INTERVAL - 1));
  assign tick_o = en_i && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r9_idle_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));

endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
  parameter int unsigned MAX_PENDING = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic done_i,
  input  logic ready_i,
  output logic owed_o,
  output logic full_o
);
  localparam int unsigned PW = $clog2(MAX_PENDING + 1);

  logic [PW-1:0] pend_q, pend_d;
  logic          dec;

  assign dec    = done_i && ready_i && (pend_q != '0);
  assign owed_o = (pend_q != '0);
  assign full_o = (pend_q == PW'(MAX_PENDING));

  always_comb begin
    pend_d = pend_q;
    if (tick_i && !dec && !full_o) pend_d = pend_q + 1'b1;
    else if (dec && !tick_i)       pend_d = pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(MAX_PENDING));
  a_r10_drain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !tick_i) |=> (pend_q == $past(pend_q) - 1'b1));

endmodule

// File: rtl/dram_ref_strobe.sv
module dram_ref_strobe #(
  parameter int unsigned T_WSU = 2,
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_RAS = 10,
  parameter int unsigned T_RP  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic gnt_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  import dram_ref_pkg::*;

  localparam int unsigned TOTAL = T_WSU + T_CSR + T_RAS + T_RP;
  localparam int unsigned CW    = $clog2(TOTAL + 1);

  ref_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = last ? cnt_q : cnt_q - 1'b1;
    case (ph_q)
      PH_IDLE: if (req_i && gnt_i) begin ph_d = PH_WSU; cnt_d = CW'(T_WSU - 1); end
      PH_WSU:  if (last)           begin ph_d = PH_CSU; cnt_d = CW'(T_CSR - 1); end
      PH_CSU:  if (last)           begin ph_d = PH_ACT; cnt_d = CW'(T_RAS - 1); end
      PH_ACT:  if (last)           begin ph_d = PH_PRE; cnt_d = CW'(T_RP - 1);  end
      PH_PRE:  if (last)           begin ph_d = PH_IDLE; cnt_d = '0;            end
      default:                     begin ph_d = PH_IDLE; cnt_d = '0;            end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o  = (ph_q != PH_IDLE);
  assign done_o  = (ph_q == PH_PRE) && last;
  assign ras_n_o = (ph_q != PH_ACT);
  assign cas_n_o = !((ph_q == PH_CSU) || (ph_q == PH_ACT));

  a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> $past(!cas_n_o));
  a_r4_cas_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n_o) |-> $rose(ras_n_o));
  a_r7_start_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_i && gnt_i));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && ras_n_o && cas_n_o);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned CLK_MHZ      = 200,
  parameter int unsigned STARTUP_US   = 200,
  parameter int unsigned RETENTION_US = 32000,
  parameter int unsigned ROWS         = 2048,
  parameter int unsigned MARGIN       = 16,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned MAX_PENDING  = 4,
  parameter int unsigned WSU_NS       = 10,
  parameter int unsigned CSR_NS       = 5,
  parameter int unsigned RAS_NS       = 50,
  parameter int unsigned RP_NS        = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic ref_done_o,
  output logic mem_ready_o
);
  import dram_ref_pkg::*;

  localparam int unsigned START_CYC = CLK_MHZ * STARTUP_US;
  localparam int unsigned INTERVAL  = (CLK_MHZ * RETENTION_US) / ROWS - MARGIN;
  localparam int unsigned T_WSU     = ns_to_cyc(WSU_NS, CLK_MHZ);
  localparam int unsigned T_CSR     = ns_to_cyc(CSR_NS, CLK_MHZ);
  localparam int unsigned T_RAS     = ns_to_cyc(RAS_NS, CLK_MHZ);
  localparam int unsigned T_RP      = ns_to_cyc(RP_NS, CLK_MHZ);

  logic init_req, ready, tick, owed, full, busy, done, want;

  dram_ref_powerup #(.START_CYC(START_CYC), .INIT_CYCLES(INIT_CYCLES)) u_powerup (
    .clk(clk), .rst_n(rst_n), .done_i(done),
    .init_req_o(init_req), .ready_o(ready)
  );

  dram_ref_interval #(.INTERVAL(INTERVAL)) u_interval (
    .clk(clk), .rst_n(rst_n), .en_i(ready), .tick_o(tick)
  );

  dram_ref_backlog #(.MAX_PENDING(MAX_PENDING)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .done_i(done), .ready_i(ready),
    .owed_o(owed), .full_o(full)
  );

  assign want = init_req || owed;

  dram_ref_strobe #(.T_WSU(T_WSU), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_strobe (
    .clk(clk), .rst_n(rst_n), .req_i(want), .gnt_i(ref_gnt_i),
    .busy_o(busy), .done_o(done), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o)
  );

  assign ref_req_o    = want || busy;
  assign ref_urgent_o = full;
  assign we_n_o       = 1'b1;
  assign ref_done_o   = done;
  assign mem_ready_o  = ready;

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ref_req_o);
  a_r6_we_high_at_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> we_n_o && $past(we_n_o));

endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;

  localparam int MHZ = 200;
  localparam int START = MHZ * 2;
  localparam int INTV = (MHZ * 64) / 16 - 8;
  localparam int NINIT = 8;
  localparam int MAXP = 3;
  localparam int W = 2, C = 1, R = 10, P = 6;
  localparam int L = W + C + R + P;

  logic clk, rst_n, gnt;
  logic req, urg, ras_n, cas_n, we_n, done, ready;

  int tests, fails, cyc;

  dram_refresh_sched #(
    .CLK_MHZ(MHZ), .STARTUP_US(2), .RETENTION_US(64), .ROWS(16), .MARGIN(8),
    .INIT_CYCLES(NINIT), .MAX_PENDING(MAXP),
    .WSU_NS(10), .CSR_NS(5), .RAS_NS(50), .RP_NS(30)
  ) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt_i(gnt), .ref_req_o(req),
    .ref_urgent_o(urg), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ref_done_o(done), .mem_ready_o(ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural model: integers only.
  int m_wait, m_inits, m_pend, m_k, m_tcnt;
  bit m_ready;

  function automatic bit exp_req();
    return (m_k >= 0) || (m_pend > 0) || (!m_ready && m_wait == START);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wait = 0; m_inits = 0; m_pend = 0; m_k = -1; m_tcnt = 0; m_ready = 0; cyc = 0;
    end else begin
      bit d, t, rq, was_ready;
      cyc++;
      d = (m_k == L - 1);
      t = m_ready && (m_tcnt == INTV - 1);
      rq = exp_req();
      was_ready = m_ready;
      if (m_k >= 0) m_k = d ? -1 : m_k + 1;
      else if (rq && gnt) m_k = 0;
      if (!m_ready && m_wait < START) m_wait++;
      if (was_ready) m_tcnt = (m_tcnt == INTV - 1) ? 0 : m_tcnt + 1;
      if (d && !was_ready) begin
        m_inits++;
        if (m_inits == NINIT) m_ready = 1;
      end
      m_pend = m_pend + int'(t) - int'(d && was_ready && m_pend > 0);
      if (m_pend > MAXP) m_pend = MAXP;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 cas_n", cas_n, !(m_k >= W && m_k < W + C + R));
      check("R5 ras_n", ras_n, !(m_k >= W + C && m_k < W + C + R));
      check("R6 we_n", we_n, 1);
      check("R7 ref_req", req, exp_req());
      check("R8 ref_done", done, m_k == L - 1);
      check("R10 ref_urgent", urg, m_pend >= MAXP);
      check("R3 mem_ready", ready, m_ready);
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int ndone, t1, t2;
    tests = 0; fails = 0;
    rst_n = 1'b0; gnt = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset ras_n", ras_n, 1);
    check("R1 reset cas_n", cas_n, 1);
    check("R1 reset we_n", we_n, 1);
    check("R1 reset ref_req", req, 0);
    check("R1 reset ready", ready, 0);
    check("R1 reset done", done, 0);
    check("R1 reset urgent", urg, 0);
    rst_n = 1'b1;

    repeat (START - 1) @(negedge clk);
    check("R2 no request during start-up", req, 0);
    @(negedge clk);
    check("R2 request after start-up", req, 1);

    repeat (200) @(negedge clk);
    check("R7 no refresh without grant", ras_n, 1);
    check("R3 not ready without refreshes", ready, 0);

    gnt = 1'b1;
    ndone = 0;
    while (!ready) begin
      @(negedge clk);
      if (done) ndone++;
    end
    check("R3 init refresh count at ready", ndone, NINIT);

    while (!done) @(negedge clk);
    t1 = cyc;
    @(negedge clk);
    while (!done) @(negedge clk);
    t2 = cyc;
    check("R9 spacing of refreshes", t2 - t1, INTV);

    gnt = 1'b0;
    repeat (5 * INTV) @(negedge clk);
    check("R10 urgent at full backlog", urg, 1);
    check("R7 strobes idle without grant", ras_n, 1);

    gnt = 1'b1;
    ndone = 0;
    while (req) begin
      @(negedge clk);
      if (done) ndone++;
    end
    check("R10 drained backlog count", ndone, MAXP);
    check("R10 urgent cleared", urg, 0);
    check("R3 ready sticky", ready, 1);

    repeat (2 * INTV) @(negedge clk);
    finish_run();
  end

endmodule